// File: doc/BRIEF.md
# Eight-Pin I/O Port Controller

This block controls one port of eight general-purpose pins. Software sets each pin's drive mode through a 2-bit code and writes the port's output bits. A write-protect mask keeps chosen output bits from changing when the whole port is written, and a per-pin switch turns off the digital input path. The block drives the pad output-enable and output-value lines. It samples the pad inputs through a two-flop synchronizer into a pin-state value that software can read.

Each pin also appears as its own word in an alias window. A single write there loads or inverts one output bit with no read-modify-write of the port, and a single read returns that pin's state. The bus is a simple single-cycle select/write interface with a combinational read path.

Each pin has its own drive state machine `pio_pin_drv` with four states:
- DRV_OFF: the pad is released.
- DRV_LOW: the pad is driven 0.
- DRV_HIGH: the pad is driven 1.
- DRV_BOOST: a short strong-high pulse used in quasi-bidirectional mode.

The transitions are:
- Input mode goes to DRV_OFF.
- Push-pull goes to DRV_LOW or DRV_HIGH, following the output bit.
- Open-drain goes to DRV_LOW for a 0 and DRV_OFF for a 1.
- Quasi-bidirectional goes to DRV_LOW for a 0.
- In quasi-bidirectional mode, a 0-to-1 change of the output bit enters DRV_BOOST. The machine stays there for BOOST_CYCLES clocks and then moves to DRV_OFF.
- In quasi-bidirectional mode, an output bit that is 1 and unchanged stays in DRV_OFF.

Top module: `pio_port`

## Requirements
- R1: After reset, every pin is in input mode with pad_oe all 0. Output data reads 0xFF, and the mask and input-disable registers read 0.
- R2: Mode code 0 (input) releases the pad: pad_oe is 0.
- R3: Mode code 1 (push-pull) drives the pad with pad_out equal to the output bit. The mode register is at offset 0x00, with pin n in bits 2n+1:2n. The pads take a new value one clock after the register write.
- R4: Mode code 2 (open-drain) drives low when the output bit is 0 and releases the pad when it is 1. It never drives high.
- R5: Mode code 3 (quasi-bidirectional) drives low for a 0. A 0-to-1 change of the output bit drives high for exactly 2 clocks and then releases the pad. A steady 1 leaves the pad released.
- R6: A write to the output data register at offset 0x04 updates all unmasked bits in the same cycle. Bits whose bit in the mask register (offset 0x08, bit n = pin n) is 1 keep their value.
- R7: The input-disable register at offset 0x0C holds pin n at bit 16+n. A set bit makes that pin's state read 0.
- R8: Pad inputs pass through two flops before they show in the pin-state register at offset 0x10, bits 7:0.
- R9: The alias word of pin y is at 0x100 + 0x20*PORT_ID + 4*y. A write with bit 1 clear loads bit 0 into output bit y. A read returns pin y's state in bit 0 and 0 in every other bit.
- R10: An alias write with bit 1 set XORs bit 0 into output bit y. No other output bit changes.
- R11: Alias writes are not blocked by the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | PINS | Pad input levels |
| pad_oe | output | PINS | Pad output enable |
| pad_out | output | PINS | Pad output value |

## Verification
The drive logic is tried with four port-wide patterns: all push-pull, all open-drain, all input and all quasi-bidirectional. A fifth pattern mixes all four modes across pin pairs. Each pattern is paired with an output byte chosen so that the pins driving high, driving low and released are all distinct. This shows up any swapped mode code or a wrong enable rule.

Directed sequences cover the following:
- The exact boost window after a single rising output bit.
- A masked whole-port write set against unmasked alias loads and toggles.
- The two-clock synchronizer delay.
- The input-disable forcing of pin-state reads.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        MODE_IN = 2'd0,
        MODE_PP = 2'd1,
        MODE_OD = 2'd2,
        MODE_QB = 2'd3
    } pin_mode_e;

    typedef enum logic [1:0] {
        DRV_OFF   = 2'd0,
        DRV_LOW   = 2'd1,
        DRV_HIGH  = 2'd2,
        DRV_BOOST = 2'd3
    } drv_state_e;

    localparam int OFS_MODE  = 'h00;
    localparam int OFS_DATA  = 'h04;
    localparam int OFS_MASK  = 'h08;
    localparam int OFS_INDIS = 'h0C;
    localparam int OFS_STATE = 'h10;
    localparam int ALIAS_ORG = 'h100;
    localparam int PORT_STRIDE = 'h20;
    localparam int INDIS_LSB = 16;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/pio_pin_drv.sv
module pio_pin_drv
    import pio_pkg::*;
#(
    parameter int BOOST_CYCLES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode_i,
    input  logic      dout_i,
    output logic      oe_o,
    output logic      val_o
);
    localparam int CNT_W = $clog2(BOOST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BOOST_CYCLES - 1);

    drv_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             prev_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DRV_OFF;
            cnt_q   <= '0;
            prev_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= dout_i;
        end
    end

    // Next state
    always_comb begin
        state_d = DRV_OFF;
        cnt_d   = '0;
        unique case (mode_i)
            MODE_IN: state_d = DRV_OFF;
            MODE_PP: state_d = dout_i ? DRV_HIGH : DRV_LOW;
            MODE_OD: state_d = dout_i ? DRV_OFF : DRV_LOW;
            MODE_QB: begin
                if (!dout_i) begin
                    state_d = DRV_LOW;
                end else if (!prev_q) begin
                    state_d = DRV_BOOST;
                end else if (state_q == DRV_BOOST && cnt_q != CNT_LAST) begin
                    state_d = DRV_BOOST;
                    cnt_d   = cnt_q + 1'b1;
                end else begin
                    state_d = DRV_OFF;
                end
            end
            default: state_d = DRV_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        oe_o  = 1'b0;
        val_o = 1'b0;
        unique case (state_q)
            DRV_OFF:   begin oe_o = 1'b0; val_o = 1'b0; end
            DRV_LOW:   begin oe_o = 1'b1; val_o = 1'b0; end
            DRV_HIGH:  begin oe_o = 1'b1; val_o = 1'b1; end
            DRV_BOOST: begin oe_o = 1'b1; val_o = 1'b1; end
            default:   begin oe_o = 1'b0; val_o = 1'b0; end
        endcase
    end

    assert_input_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_IN) |=> !oe_o);

    assert_pp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PP) |=> (oe_o && (val_o == $past(dout_i))));

    assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OD) |=> !(oe_o && val_o));

    assert_qb_rise_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_QB && dout_i && !prev_q) |=> (oe_o && val_o));

    assert_qb_low_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_QB && !dout_i) |=> (oe_o && !val_o));
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int PINS    = 8,
    parameter int ADDR_W  = 12,
    parameter int PORT_ID = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [PINS-1:0]     sync_i,
    output logic [2*PINS-1:0]   mode_o,
    output logic [PINS-1:0]     dout_o
);
    localparam logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'(ALIAS_ORG + PORT_STRIDE * PORT_ID);

    logic [2*PINS-1:0] mode_q;
    logic [PINS-1:0]   dout_q, mask_q, indis_q;
    logic [PINS-1:0]   pin_state;
    logic [PINS-1:0]   alias_onehot;
    logic [2:0]        alias_idx;
    logic              alias_hit, alias_bit;
    logic              wr, rd;
    logic              hit_mode, hit_data, hit_mask, hit_indis, hit_state;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign wr = bus_sel && bus_wr;
    assign rd = bus_sel && !bus_wr;

    assign hit_mode  = (bus_addr == ADDR_W'(OFS_MODE));
    assign hit_data  = (bus_addr == ADDR_W'(OFS_DATA));
    assign hit_mask  = (bus_addr == ADDR_W'(OFS_MASK));
    assign hit_indis = (bus_addr == ADDR_W'(OFS_INDIS));
    assign hit_state = (bus_addr == ADDR_W'(OFS_STATE));

    assign alias_idx = bus_addr[4:2];
    assign alias_hit = (bus_addr[ADDR_W-1:5] == ALIAS_BASE[ADDR_W-1:5]) &&
                       (bus_addr[1:0] == 2'b00) && (int'(alias_idx) < PINS);

    always_comb begin
        alias_onehot = '0;
        if (alias_hit) alias_onehot[alias_idx] = 1'b1;
    end

    // New value for the addressed pin: load or toggle
    assign alias_bit = bus_wdata[1] ? (dout_q[alias_idx] ^ bus_wdata[0]) : bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            dout_q  <= '1;
            mask_q  <= '0;
            indis_q <= '0;
        end else if (wr) begin
            if (hit_mode)  mode_q  <= bus_wdata[2*PINS-1:0];
            if (hit_mask)  mask_q  <= bus_wdata[PINS-1:0];
            if (hit_indis) indis_q <= bus_wdata[INDIS_LSB +: PINS];
            if (hit_data)
                dout_q <= (bus_wdata[PINS-1:0] & ~mask_q) | (dout_q & mask_q);
            else if (alias_hit)
                dout_q <= (dout_q & ~alias_onehot) | (alias_onehot & {PINS{alias_bit}});
        end
    end

    assign pin_state = sync_i & ~indis_q;

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (hit_mode)       bus_rdata[2*PINS-1:0] = mode_q;
            else if (hit_data)  bus_rdata[PINS-1:0]   = dout_q;
            else if (hit_mask)  bus_rdata[PINS-1:0]   = mask_q;
            else if (hit_indis) bus_rdata[INDIS_LSB +: PINS] = indis_q;
            else if (hit_state) bus_rdata[PINS-1:0]   = pin_state;
            else if (alias_hit) bus_rdata[0]          = pin_state[alias_idx];
        end
    end

    assign mode_o = mode_q;
    assign dout_o = dout_q;

    assert_mask_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_data) |=> ((dout_q & $past(mask_q)) == ($past(dout_q) & $past(mask_q))));

    assert_alias_single_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && alias_hit) |=> (((dout_q ^ $past(dout_q)) & ~$past(alias_onehot)) == '0));

    assert_disabled_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_state) |-> ((bus_rdata[PINS-1:0] & indis_q) == '0));
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int PINS         = 8,
    parameter int ADDR_W       = 12,
    parameter int PORT_ID      = 0,
    parameter int BOOST_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out
);
    logic [PINS-1:0]   pin_sync;
    logic [2*PINS-1:0] mode_flat;
    logic [PINS-1:0]   dout;

    pio_sync #(.W(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pin_sync)
    );

    pio_regs #(.PINS(PINS), .ADDR_W(ADDR_W), .PORT_ID(PORT_ID)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_i    (pin_sync),
        .mode_o    (mode_flat),
        .dout_o    (dout)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pio_pin_drv #(.BOOST_CYCLES(BOOST_CYCLES)) u_drv (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (pin_mode_e'(mode_flat[2*i +: 2])),
            .dout_i (dout[i]),
            .oe_o   (pad_oe[i]),
            .val_o  (pad_out[i])
        );
    end
endmodule

// File: tb/pio_port_tb.sv
module pio_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe, pad_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // {mode word, output byte, expected pad_oe, expected pad_out}
    localparam logic [39:0] VEC [5] = '{
        {16'h5555, 8'hA5, 8'hFF, 8'hA5},   // R3 all push-pull
        {16'hAAAA, 8'h3C, 8'hC3, 8'h00},   // R4 all open-drain
        {16'h0000, 8'h0F, 8'h00, 8'h00},   // R2 all input
        {16'hFA50, 8'h96, 8'h6C, 8'h04},   // R2 R3 R4 R5 mixed
        {16'hFFFF, 8'h55, 8'hAA, 8'h00}    // R5 all quasi, steady
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", {24'b0, pad_oe}, 32'h0);
        bus_read(12'h000, rd); check("R1 mode", rd, 32'h0);
        bus_read(12'h004, rd); check("R1 data", rd, 32'hFF);
        bus_read(12'h008, rd); check("R1 mask", rd, 32'h0);
        bus_read(12'h00C, rd); check("R1 indis", rd, 32'h0);

        // Table of mode/data patterns
        for (int i = 0; i < 5; i++) begin
            bus_write(12'h000, {16'h0, VEC[i][39:24]});
            bus_write(12'h004, {24'h0, VEC[i][23:16]});
            repeat (6) @(negedge clk);
            check("R2-5 table pad_oe", {24'b0, pad_oe}, {24'b0, VEC[i][15:8]});
            check("R2-5 table pad_out", {24'b0, pad_out}, {24'b0, VEC[i][7:0]});
        end

        // R5 boost window; quasi mode already active
        bus_write(12'h004, 32'h00);
        repeat (4) @(negedge clk);
        check("R5 all low", {24'b0, pad_oe, pad_out}, {24'b0, 8'hFF, 8'h00});
        bus_write(12'h004, 32'h01);
        check("R3 one clock latency", {30'b0, pad_oe[0], pad_out[0]}, 32'h2);
        @(negedge clk);
        check("R5 boost clock 1", {30'b0, pad_oe[0], pad_out[0]}, 32'h3);
        @(negedge clk);
        check("R5 boost clock 2", {30'b0, pad_oe[0], pad_out[0]}, 32'h3);
        @(negedge clk);
        check("R5 released", {30'b0, pad_oe[0], pad_out[0]}, 32'h0);
        @(negedge clk);
        check("R5 stays released", {30'b0, pad_oe[0], pad_out[0]}, 32'h0);

        // R6 masked whole-port write
        bus_write(12'h004, 32'hFF);
        bus_write(12'h008, 32'hF0);
        bus_write(12'h004, 32'h00);
        bus_read(12'h004, rd); check("R6 masked write", rd, 32'hF0);
        bus_write(12'h008, 32'h00);
        bus_write(12'h004, 32'h3C);
        bus_read(12'h004, rd); check("R6 unmasked write", rd, 32'h3C);
        bus_write(12'h004, 32'hFF);
        bus_write(12'h008, 32'hF0);
        bus_write(12'h004, 32'h00);

        // R11 alias ignores mask, R10 toggle, R9 load
        bus_write(12'h114, 32'h0);
        bus_read(12'h004, rd); check("R11 alias past mask", rd, 32'hD0);
        bus_write(12'h100, 32'h3);
        bus_read(12'h004, rd); check("R10 toggle pin0", rd, 32'hD1);
        bus_write(12'h100, 32'h2);
        bus_read(12'h004, rd); check("R10 toggle by zero", rd, 32'hD1);
        bus_write(12'h11C, 32'h0);
        bus_read(12'h004, rd); check("R9 alias load pin7", rd, 32'h51);

        // R8 synchronizer delay
        @(negedge clk);
        pad_in = 8'hA5;
        @(negedge clk);
        bus_read(12'h010, rd); check("R8 after one clock", rd, 32'h00);
        @(negedge clk);
        bus_read(12'h010, rd); check("R8 after two clocks", rd, 32'hA5);
        bus_read(12'h100, rd); check("R9 alias read pin0", rd, 32'h1);
        bus_read(12'h104, rd); check("R9 alias read pin1", rd, 32'h0);

        // R7 input disable
        bus_write(12'h00C, 32'h000F_0000);
        bus_read(12'h00C, rd); check("R7 indis readback", rd, 32'h000F_0000);
        bus_read(12'h010, rd); check("R7 state forced", rd, 32'hA0);
        bus_read(12'h100, rd); check("R7 alias forced", rd, 32'h0);
        bus_read(12'h11C, rd); check("R7 enabled pin", rd, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule